// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block moves outgoing packets from memory to a MAC transmit port. Software builds a chain of descriptors in memory, points the engine at the first one and sets the run bit. For each descriptor the engine reads the control word, then the buffer address and the link to the next descriptor. It fetches the buffer one 32-bit word at a time and sends the bytes on a byte stream with a last-byte flag. When a packet is done it writes the control word back with the empty flag set, and it follows the link to the next descriptor.

When the engine reaches a descriptor whose empty flag is set, it holds there. It reads that descriptor's control word again after a fixed poll gap, so software can add packets to the chain while the engine runs. A small status register reports completed packets, zero-length descriptors and memory errors.

Top module: `txdma_engine`

## Requirements
- R1: After reset, the run bit, the descriptor address and every status bit read 0, and neither `mem_req` nor `tx_valid` is high.
- R2: For each descriptor the engine reads the control word at offset 4 first. It then reads the buffer address at offset 0 and the next-descriptor address at offset 8. It never reads the pad word at offset 12. In the control word, bit 31 is the empty flag and bits 11:0 are the byte length.
- R3: A packet of length L goes out as exactly L stream bytes, taken in ascending address order with the least significant byte of each word first. `tx_last` is high on the final byte only. Each byte is held until `tx_ready` accepts it.
- R4: After the final byte is accepted, the engine writes the control word back to offset 4. All original bits are kept and bit 31 is set.
- R5: After the write-back, the descriptor address register holds the next-descriptor address, and the engine goes on to that descriptor.
- R6: If the control word read has bit 31 set, no bytes are sent and the descriptor address does not change. The same control word is read again every POLL_GAP idle cycles while the run bit is set.
- R7: Register select 0 is the control register, and its bit 0 is the run bit. The engine starts a descriptor only while the run bit is 1. Clearing the run bit lets the current packet finish and be written back, and no further descriptor is fetched.
- R8: Status bit 0 reads 1 while the completed-packet count is non-zero. Each sent packet adds one. Each write to status (select 2) with bit 0 set subtracts one, and a write with bit 0 clear changes nothing.
- R9: A descriptor of length 0 sends no bytes and does not count as sent. It sets status bit 1 and is written back and stepped over like any other descriptor.
- R10: A granted access with `mem_err` high sets status bit 3 and clears the run bit. It also abandons the descriptor: there is no write-back and the descriptor address stays on it.
- R11: Status bits 1 and 3 are cleared by writing 1 to them and are unchanged by writing 0. Status bits 31:24 always read 0.
- R12: While `mem_req` is high and `mem_gnt` is low, the request, address, write flag and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 descriptor address, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted in this cycle; read data is valid with it |
| mem_err | input | 1 | Granted access failed |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | MAC accepts the byte |

## Verification
Two situations are hard to reach from the ports. The first is turning the engine off in the middle of a packet. The bench waits until it sees the first valid byte of a long packet and then clears the run bit. It then checks that the whole packet arrives, that its descriptor is written back, and that the next valid descriptor in the chain is never read. The second is a memory error on a buffer word after part of the packet has already gone out. The memory model raises the error on one chosen address. Random grant and ready stalls run throughout, so every handshake is also exercised under back-pressure.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned LEN_W     = 12;
    localparam int unsigned EMPTY_BIT = 31;

    localparam int unsigned OFS_BUF   = 0;
    localparam int unsigned OFS_CTRL  = 4;
    localparam int unsigned OFS_LINK  = 8;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_DESC = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_BUF,
        ST_LINK,
        ST_FETCH,
        ST_SEND,
        ST_WBACK,
        ST_POLL
    } dma_state_e;

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
    import txdma_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned SENT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [AW-1:0]     cur_daddr,
    input  logic              ev_sent,
    input  logic              ev_underrun,
    input  logic              ev_buserr,
    output logic              run_en
);

    localparam logic [SENT_W-1:0] SENT_MAX = {SENT_W{1'b1}};

    typedef struct packed {
        logic              run;
        logic [SENT_W-1:0] sent;
        logic              urun;
        logic              berr;
    } regs_t;

    regs_t q, d;

    logic wr_ctrl, wr_stat, dec;

    always_comb begin
        d       = q;
        wr_ctrl = reg_we && (reg_addr == SEL_CTRL);
        wr_stat = reg_we && (reg_addr == SEL_STAT);
        dec     = wr_stat && reg_wdata[0] && (q.sent != '0);

        if (wr_ctrl) d.run = reg_wdata[0];
        if (ev_buserr) d.run = 1'b0;

        unique case ({ev_sent, dec})
            2'b10:   d.sent = (q.sent == SENT_MAX) ? q.sent : q.sent + 1'b1;
            2'b01:   d.sent = q.sent - 1'b1;
            default: d.sent = q.sent;
        endcase

        if (ev_underrun)                   d.urun = 1'b1;
        else if (wr_stat && reg_wdata[1])  d.urun = 1'b0;

        if (ev_buserr)                     d.berr = 1'b1;
        else if (wr_stat && reg_wdata[3])  d.berr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            SEL_CTRL: reg_rdata = {{(WORD_W-1){1'b0}}, q.run};
            SEL_DESC: reg_rdata = WORD_W'(cur_daddr);
            SEL_STAT: reg_rdata = {{(WORD_W-4){1'b0}}, q.berr, 1'b0, q.urun, (q.sent != '0)};
            default:  reg_rdata = '0;
        endcase
    end

    assign run_en = q.run;

endmodule

// File: rtl/txdma_core.sv
module txdma_core
    import txdma_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned POLL_GAP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              daddr_we,
    input  logic [AW-1:0]     daddr_wdata,
    output logic [AW-1:0]     cur_daddr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              ev_sent,
    output logic              ev_underrun,
    output logic              ev_buserr
);

    localparam int unsigned PCW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

    typedef struct packed {
        dma_state_e        st;
        logic [AW-1:0]     daddr;
        logic [AW-1:0]     bufp;
        logic [AW-1:0]     link;
        logic [AW-1:0]     wofs;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] word;
        logic [LEN_W-1:0]  remain;
        logic [1:0]        bidx;
        logic [PCW-1:0]    pcnt;
    } core_t;

    core_t q, d;

    logic [LEN_W-1:0] cur_len;
    assign cur_len = q.ctrl[LEN_W-1:0];

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (q.st)
            ST_CTRL:  begin mem_req = 1'b1; mem_addr = q.daddr + AW'(OFS_CTRL); end
            ST_BUF:   begin mem_req = 1'b1; mem_addr = q.daddr + AW'(OFS_BUF);  end
            ST_LINK:  begin mem_req = 1'b1; mem_addr = q.daddr + AW'(OFS_LINK); end
            ST_FETCH: begin mem_req = 1'b1; mem_addr = q.bufp + q.wofs;         end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.daddr + AW'(OFS_CTRL);
                mem_wdata = q.ctrl | (WORD_W'(1) << EMPTY_BIT);
            end
            default: ;
        endcase
    end

    assign tx_valid = (q.st == ST_SEND);
    assign tx_data  = q.word[7:0];
    assign tx_last  = (q.st == ST_SEND) && (q.remain == LEN_W'(1));

    always_comb begin
        d           = q;
        ev_sent     = 1'b0;
        ev_underrun = 1'b0;
        ev_buserr   = 1'b0;

        if (daddr_we) d.daddr = daddr_wdata;

        if (mem_req && mem_gnt && mem_err) begin
            ev_buserr = 1'b1;
            d.st      = ST_IDLE;
        end else begin
            unique case (q.st)
                ST_IDLE: if (run_en) d.st = ST_CTRL;
                ST_CTRL: if (mem_gnt) begin
                    if (mem_rdata[EMPTY_BIT]) begin
                        d.st   = ST_POLL;
                        d.pcnt = '0;
                    end else begin
                        d.ctrl = mem_rdata;
                        d.st   = ST_BUF;
                    end
                end
                ST_BUF: if (mem_gnt) begin
                    d.bufp = AW'(mem_rdata);
                    d.st   = ST_LINK;
                end
                ST_LINK: if (mem_gnt) begin
                    d.link   = AW'(mem_rdata);
                    d.remain = cur_len;
                    d.wofs   = '0;
                    if (cur_len == '0) begin
                        ev_underrun = 1'b1;
                        d.st        = ST_WBACK;
                    end else begin
                        d.st = ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_gnt) begin
                    d.word = mem_rdata;
                    d.bidx = '0;
                    d.wofs = q.wofs + AW'(4);
                    d.st   = ST_SEND;
                end
                ST_SEND: if (tx_ready) begin
                    d.remain = q.remain - 1'b1;
                    if (q.remain == LEN_W'(1)) begin
                        d.st = ST_WBACK;
                    end else if (q.bidx == 2'd3) begin
                        d.st = ST_FETCH;
                    end else begin
                        d.word = q.word >> 8;
                        d.bidx = q.bidx + 1'b1;
                    end
                end
                ST_WBACK: if (mem_gnt) begin
                    ev_sent = (cur_len != '0);
                    d.daddr = q.link;
                    d.st    = run_en ? ST_CTRL : ST_IDLE;
                end
                ST_POLL: begin
                    if (!run_en)                           d.st = ST_IDLE;
                    else if (q.pcnt == PCW'(POLL_GAP - 1)) d.st = ST_CTRL;
                    else                                   d.pcnt = q.pcnt + 1'b1;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_daddr = q.daddr;

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned POLL_GAP = 16,
    parameter int unsigned SENT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);

    logic          ctl_en;
    logic          ev_sent, ev_underrun, ev_buserr;
    logic [AW-1:0] cur_daddr;
    logic          daddr_we;

    assign daddr_we = reg_we && (reg_addr == SEL_DESC);

    txdma_regs #(.AW(AW), .SENT_W(SENT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cur_daddr   (cur_daddr),
        .ev_sent     (ev_sent),
        .ev_underrun (ev_underrun),
        .ev_buserr   (ev_buserr),
        .run_en      (ctl_en)
    );

    txdma_core #(.AW(AW), .POLL_GAP(POLL_GAP)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (ctl_en),
        .daddr_we    (daddr_we),
        .daddr_wdata (AW'(reg_wdata)),
        .cur_daddr   (cur_daddr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_gnt     (mem_gnt),
        .mem_err     (mem_err),
        .mem_rdata   (mem_rdata),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_last     (tx_last),
        .tx_ready    (tx_ready),
        .ev_sent     (ev_sent),
        .ev_underrun (ev_underrun),
        .ev_buserr   (ev_buserr)
    );

endmodule

// File: rtl/txdma_checker.sv
module txdma_checker #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_gnt,
    input logic          mem_err,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          tx_ready,
    input logic          ctl_en
);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    p_byte_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    p_wback_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[31]);

    p_stream_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_req);

    p_err_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_err) |=> !ctl_en);

endmodule

bind txdma_engine txdma_checker #(.AW(AW)) u_chk (.*);

// File: tb/txdma_engine_tb.sv
module txdma_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    always #10 clk = ~clk;

    txdma_engine u_dut (.*);

    logic [31:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[9:2]];

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0] cap [0:1023];
    logic       cap_l [0:1023];
    int cap_n = 0;
    int pad_reads = 0, watch_reads = 0, hold_viol = 0;
    logic [31:0] watch_addr = 32'hFFFF_FFFF;
    logic [31:0] log_a [0:2047];
    int log_n = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic pend = 1'b0;
    logic [31:0] pend_addr = '0;

    always @(negedge clk) begin
        if (pend && (!mem_req || mem_addr != pend_addr)) hold_viol++;
        mem_gnt  = mem_req && (($urandom % 10) < 7);
        mem_err  = mem_gnt && (mem_addr == err_addr);
        tx_ready = (($urandom % 10) < 7);
        pend     = mem_req && !mem_gnt;
        pend_addr = mem_addr;
        #1;
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                if (!mem_err) mem[mem_addr[9:2]] = mem_wdata;
            end else begin
                if (log_n < 2048) log_a[log_n] = mem_addr;
                log_n++;
                if (mem_addr < 32'h200 && mem_addr[3:0] == 4'hC) pad_reads++;
                if (mem_addr == watch_addr) watch_reads++;
            end
        end
        if (tx_valid && tx_ready && cap_n < 1024) begin
            cap[cap_n] = tx_data; cap_l[cap_n] = tx_last; cap_n++;
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk); reg_addr = a; #2; v = reg_rdata;
    endtask

    task automatic wait_desc(input logic [31:0] a);
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            reg_read(2'd1, v);
            if (v == a) return;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input logic [31:0] base, input int k);
        logic [31:0] w;
        w = mem[(base + 32'(k / 4) * 4) >> 2 & 32'hFF];
        return w[8*(k%4) +: 8];
    endfunction

    task automatic set_desc(input logic [31:0] da, input logic [31:0] buf_a, input logic [31:0] ctrl, input logic [31:0] nxt);
        mem[(da >> 2) + 0] = buf_a;
        mem[(da >> 2) + 2] = nxt;
        mem[(da >> 2) + 3] = 32'hDEAD_0000;
        mem[(da >> 2) + 1] = ctrl;
    endtask

    task automatic check_pkt(input int start, input logic [31:0] base, input int len, input string req);
        int bad = 0;
        for (int k = 0; k < len; k++) begin
            if (cap[start + k] !== exp_byte(base, k)) bad++;
            if (cap_l[start + k] !== (k == len - 1)) bad++;
        end
        check(bad == 0, req, 32'(bad), 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        int lens [0:5];
        int start, log0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) mem[i] = $urandom;

        idle(3);
        rst_n = 1'b1;

        reg_read(2'd0, v); check(v == 0, "R1 run bit", v, 0);
        reg_read(2'd2, v); check(v == 0, "R1 status", v, 0);
        reg_read(2'd1, v); check(v == 0, "R1 desc addr", v, 0);
        check(!mem_req && !tx_valid, "R1 outputs idle", {30'd0, mem_req, tx_valid}, 0);

        for (int i = 0; i < 6; i++) begin
            lens[i] = 1 + int'($urandom % 32);
            set_desc(32'h100 + 32'(i) * 16, 32'h200 + 32'(i) * 32,
                     32'(lens[i]) | (32'(i % 2) << 24), 32'h100 + 32'(i + 1) * 16);
        end
        mem[32'h164 >> 2] = 32'h8000_0000;
        reg_write(2'd1, 32'h100);
        log0 = log_n;
        reg_write(2'd0, 32'h1);
        wait_desc(32'h160);
        idle(4);

        check(log_a[log0] == 32'h104 && log_a[log0+1] == 32'h100 && log_a[log0+2] == 32'h108,
              "R2 fetch order", log_a[log0+1], 32'h100);
        start = 0;
        for (int i = 0; i < 6; i++) begin
            check_pkt(start, 32'h200 + 32'(i) * 32, lens[i], "R3 packet bytes");
            start += lens[i];
            v = mem[(32'h104 + 32'(i) * 16) >> 2];
            check(v == (32'h8000_0000 | 32'(lens[i]) | (32'(i % 2) << 24)), "R4 write-back", v,
                  32'h8000_0000 | 32'(lens[i]) | (32'(i % 2) << 24));
        end
        check(cap_n == start, "R3 byte count", 32'(cap_n), 32'(start));
        reg_read(2'd1, v); check(v == 32'h160, "R5 follows link", v, 32'h160);

        watch_addr = 32'h164; watch_reads = 0; start = cap_n;
        idle(120);
        check(watch_reads >= 3, "R6 re-poll", 32'(watch_reads), 3);
        check(cap_n == start, "R6 no bytes while empty", 32'(cap_n), 32'(start));
        reg_read(2'd1, v); check(v == 32'h160, "R6 address held", v, 32'h160);

        mem[32'h174 >> 2] = 32'h8000_0000;
        set_desc(32'h160, 32'h300, 32'd7, 32'h170);
        wait_desc(32'h170);
        idle(4);
        check_pkt(start, 32'h300, 7, "R6 resume after fill");

        reg_write(2'd2, 32'h0);
        reg_read(2'd2, v); check(v[0] == 1'b1, "R8 write 0 keeps count", v, 1);
        for (int i = 0; i < 6; i++) reg_write(2'd2, 32'h1);
        reg_read(2'd2, v); check(v[0] == 1'b1, "R8 count after 6 of 7", v, 1);
        reg_write(2'd2, 32'h1);
        reg_read(2'd2, v); check(v[0] == 1'b0, "R8 count drained", v, 0);

        start = cap_n;
        mem[32'h184 >> 2] = 32'h8000_0000;
        set_desc(32'h170, 32'h300, 32'd0, 32'h180);
        wait_desc(32'h180);
        idle(4);
        reg_read(2'd2, v); check(v == 32'h2, "R9 underrun only", v, 32'h2);
        check(cap_n == start, "R9 no bytes", 32'(cap_n), 32'(start));
        v = mem[32'h174 >> 2]; check(v == 32'h8000_0000, "R9 write-back", v, 32'h8000_0000);

        reg_write(2'd2, 32'hFF00_0000);
        reg_read(2'd2, v); check(v == 32'h2, "R11 write 0 keeps, 31:24 read 0", v, 32'h2);
        reg_write(2'd2, 32'h2);
        reg_read(2'd2, v); check(v == 32'h0, "R11 clear underrun", v, 0);

        reg_write(2'd0, 32'h0);
        idle(40);
        set_desc(32'h190, 32'h380, 32'd8, 32'h1A0);
        set_desc(32'h180, 32'h340, 32'd40, 32'h190);
        start = cap_n;
        idle(80);
        check(cap_n == start, "R7 run bit off", 32'(cap_n), 32'(start));
        reg_read(2'd1, v); check(v == 32'h180, "R7 held address", v, 32'h180);

        watch_addr = 32'h194; watch_reads = 0;
        reg_write(2'd0, 32'h1);
        for (int i = 0; i < 2000 && !tx_valid; i++) @(negedge clk);
        reg_write(2'd0, 32'h0);
        idle(400);
        check(cap_n == start + 40, "R7 packet completes", 32'(cap_n - start), 40);
        check_pkt(start, 32'h340, 40, "R7 packet bytes");
        reg_read(2'd1, v); check(v == 32'h190, "R7 stops at boundary", v, 32'h190);
        check(watch_reads == 0, "R7 no further fetch", 32'(watch_reads), 0);

        err_addr = 32'h384; start = cap_n;
        reg_write(2'd0, 32'h1);
        idle(200);
        reg_read(2'd2, v); check(v[3] == 1'b1, "R10 bus error bit", v, 32'h8);
        reg_read(2'd0, v); check(v == 0, "R10 run bit cleared", v, 0);
        check(cap_n == start + 4, "R10 bytes before error", 32'(cap_n - start), 4);
        v = mem[32'h194 >> 2]; check(v[31] == 1'b0, "R10 no write-back", v, 32'd8);
        reg_read(2'd1, v); check(v == 32'h190, "R10 address held", v, 32'h190);
        reg_write(2'd2, 32'h8);
        reg_read(2'd2, v); check(v[3] == 1'b0, "R11 clear bus error", v, 0);

        check(pad_reads == 0, "R2 pad never read", 32'(pad_reads), 0);
        check(hold_viol == 0, "R12 request held", 32'(hold_viol), 0);
        finish_run();
    end

endmodule